// File: doc/BRIEF.md
# Dual Data Pointer External-Memory Unit

This unit holds the external-data pointers of an 8-bit microcontroller core and drives its single-port synchronous data SRAM. It keeps two 16-bit pointers. One of them is the active pointer for ordinary pointer operations: load, increment, read and write. The active pointer is chosen by the low bit of an auxiliary register, and that register changes only when it is stepped up or down by one.

Accesses can also use a short address. An 8-bit index register value forms the low byte and a page register forms the high byte. A dedicated fast-copy command stores the accumulator through pointer 1 and then advances pointer 1, all in a single cycle. It always uses pointer 1, whatever the select bit is. This lets a copy loop read through pointer 0 and write through pointer 1 without toggling the select bit. The core's decoder presents one command per cycle on `cmd_i`. Read data comes back one cycle later on `rdata_o` with `rdata_valid_o`.

Top module: `dxu_dual_dptr`

## Requirements
- R1: After reset both pointers are 0x0000, the auxiliary register is 0x00, and `rdata_valid_o` is low. `sram_we_o` and `sram_re_o` are low while `cmd_i` is idle (0).
- R2: Command LOAD (code 1) writes `imm_i[15:8]` into the high byte and `imm_i[7:0]` into the low byte of the active pointer. The other pointer is unchanged. `dptr_o` always shows the active pointer.
- R3: Command AUX_UP (code 8) adds 1 to the auxiliary register and AUX_DOWN (code 9) subtracts 1, both modulo 256. Bit 0 of the register selects the active pointer (0 selects pointer 0, 1 selects pointer 1). `aux_o` shows the register.
- R4: Command STEP (code 2) adds 1 to the full 16-bit active pointer. 0xFFFF becomes 0x0000.
- R5: Command RD_PTR (code 3) raises `sram_re_o` in that cycle with `sram_addr_o` equal to the active pointer. In the next cycle `rdata_valid_o` is high and `rdata_o` carries the SRAM read data.
- R6: Command WR_PTR (code 4) raises `sram_we_o` for exactly that cycle. `sram_addr_o` is the active pointer and `sram_wdata_o` is `acc_i`.
- R7: Commands RD_IDX (code 5) and WR_IDX (code 6) use the address {`page_i`, `ri_i`}. They behave otherwise as RD_PTR and WR_PTR.
- R8: Command FCOPY (code 7) raises `sram_we_o` with `sram_addr_o` equal to pointer 1 and `sram_wdata_o` equal to `acc_i`, whatever the select bit is. Pointer 1 advances by 1 (wrapping), and pointer 0 is unchanged.
- R9: `sram_we_o` and `sram_re_o` are never high together. Idle (0) and codes 10 to 15 raise no strobe and change no pointer or auxiliary state.
- R10: `rdata_o` is zero whenever `rdata_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code for this cycle |
| imm_i | input | 16 | Immediate pointer value for LOAD |
| ri_i | input | 8 | Index register value, low address byte |
| page_i | input | 8 | Page register value, high address byte |
| acc_i | input | 8 | Accumulator value for writes |
| rdata_o | output | 8 | Read result |
| rdata_valid_o | output | 1 | Read result valid |
| dptr_o | output | 16 | Active pointer value |
| aux_o | output | 8 | Auxiliary register |
| sram_addr_o | output | 16 | SRAM address |
| sram_we_o | output | 1 | SRAM write enable |
| sram_re_o | output | 1 | SRAM read enable |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_rdata_i | input | 8 | SRAM read data, valid one cycle after `sram_re_o` |

## Verification
The bench builds the unit with its default widths: a 16-bit address, an 8-bit data path and an 8-bit auxiliary register. These widths put the 0xFFFF-to-0x0000 pointer wrap within reach of a single load followed by one step or fast copy. Stepping the auxiliary register down from zero reaches its 0x00-to-0xFF wrap, which selects pointer 1. A shadow model of both pointers and of memory predicts every strobe and address, and the expected read bytes are queued for a monitor to compare. This covers fast copies issued under either select value, paged index accesses that overlap pointer writes, and back-to-back reads.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  typedef enum logic [3:0] {
    CMD_IDLE     = 4'd0,
    CMD_LOAD     = 4'd1,
    CMD_STEP     = 4'd2,
    CMD_RD_PTR   = 4'd3,
    CMD_WR_PTR   = 4'd4,
    CMD_RD_IDX   = 4'd5,
    CMD_WR_IDX   = 4'd6,
    CMD_FCOPY    = 4'd7,
    CMD_AUX_UP   = 4'd8,
    CMD_AUX_DOWN = 4'd9
  } dxu_cmd_e;

  localparam int unsigned NUM_PTR = 2;
  localparam int unsigned FC_PTR  = 1;
endpackage

// File: rtl/dxu_ptr_bank.sv
module dxu_ptr_bank #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_PTR = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PTR-1:0]             ld_i,
  input  logic [NUM_PTR-1:0]             inc_i,
  input  logic [ADDR_W-1:0]              ld_val_i,
  output logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_o
);
  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    logic [ADDR_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ptr_q <= '0;
      else if (ld_i[k])  ptr_q <= ld_val_i;
      else if (inc_i[k]) ptr_q <= ptr_q + 1'b1;  // natural wrap
    end
    assign ptr_o[k] = ptr_q;
  end
endmodule

// File: rtl/dxu_aux_reg.sv
module dxu_aux_reg #(
  parameter int unsigned AUX_W   = 8,
  parameter int unsigned SEL_BIT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             down_i,
  output logic [AUX_W-1:0] aux_o,
  output logic             sel_o
);
  logic [AUX_W-1:0] aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     aux_q <= '0;
    else if (up_i)   aux_q <= aux_q + 1'b1;
    else if (down_i) aux_q <= aux_q - 1'b1;
  end

  assign aux_o = aux_q;
  assign sel_o = aux_q[SEL_BIT];
endmodule

// File: rtl/dxu_xram_port.sv
module dxu_xram_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAGE_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ptr_i,
  input  logic              wr_ptr_i,
  input  logic              rd_idx_i,
  input  logic              wr_idx_i,
  input  logic              fcopy_i,
  input  logic [ADDR_W-1:0] act_ptr_i,
  input  logic [ADDR_W-1:0] fc_ptr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DATA_W-1:0] ri_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_we_o,
  output logic              sram_re_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic idx_acc;
  logic pend_q;

  assign idx_acc = rd_idx_i | wr_idx_i;

  always_comb begin
    if (idx_acc)      sram_addr_o = {page_i, ri_i};
    else if (fcopy_i) sram_addr_o = fc_ptr_i;
    else              sram_addr_o = act_ptr_i;
  end

  assign sram_we_o    = wr_ptr_i | wr_idx_i | fcopy_i;
  assign sram_re_o    = rd_ptr_i | rd_idx_i;
  assign sram_wdata_o = sram_we_o ? acc_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= sram_re_o;
  end

  assign rdata_valid_o = pend_q;
  assign rdata_o       = pend_q ? sram_rdata_i : '0;
endmodule

// File: rtl/dxu_dual_dptr.sv
module dxu_dual_dptr
  import dxu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned AUX_W   = 8,
  parameter int unsigned SEL_BIT = 0,
  localparam int unsigned PAGE_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [DATA_W-1:0] ri_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic [ADDR_W-1:0] dptr_o,
  output logic [AUX_W-1:0]  aux_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_we_o,
  output logic              sram_re_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i
);
  dxu_cmd_e cmd;
  logic do_load, do_step, do_rd_ptr, do_wr_ptr, do_rd_idx, do_wr_idx;
  logic do_fcopy, do_up, do_down;
  logic sel;
  logic [NUM_PTR-1:0]             ld_vec, inc_vec;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrs;

  assign cmd = dxu_cmd_e'(cmd_i);

  always_comb begin
    do_load   = 1'b0;
    do_step   = 1'b0;
    do_rd_ptr = 1'b0;
    do_wr_ptr = 1'b0;
    do_rd_idx = 1'b0;
    do_wr_idx = 1'b0;
    do_fcopy  = 1'b0;
    do_up     = 1'b0;
    do_down   = 1'b0;
    case (cmd)
      CMD_LOAD:     do_load   = 1'b1;
      CMD_STEP:     do_step   = 1'b1;
      CMD_RD_PTR:   do_rd_ptr = 1'b1;
      CMD_WR_PTR:   do_wr_ptr = 1'b1;
      CMD_RD_IDX:   do_rd_idx = 1'b1;
      CMD_WR_IDX:   do_wr_idx = 1'b1;
      CMD_FCOPY:    do_fcopy  = 1'b1;
      CMD_AUX_UP:   do_up     = 1'b1;
      CMD_AUX_DOWN: do_down   = 1'b1;
      default: ;
    endcase
  end

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_en
    localparam logic KSEL = (k != 0);
    assign ld_vec[k]  = do_load & (sel == KSEL);
    assign inc_vec[k] = (do_step & (sel == KSEL)) | (do_fcopy & (k == FC_PTR));
  end

  dxu_aux_reg #(.AUX_W(AUX_W), .SEL_BIT(SEL_BIT)) u_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_i   (do_up),
    .down_i (do_down),
    .aux_o  (aux_o),
    .sel_o  (sel)
  );

  dxu_ptr_bank #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld_vec),
    .inc_i    (inc_vec),
    .ld_val_i (imm_i),
    .ptr_o    (ptrs)
  );

  assign dptr_o = ptrs[sel];

  dxu_xram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_ptr_i      (do_rd_ptr),
    .wr_ptr_i      (do_wr_ptr),
    .rd_idx_i      (do_rd_idx),
    .wr_idx_i      (do_wr_idx),
    .fcopy_i       (do_fcopy),
    .act_ptr_i     (dptr_o),
    .fc_ptr_i      (ptrs[FC_PTR]),
    .page_i        (page_i),
    .ri_i          (ri_i),
    .acc_i         (acc_i),
    .sram_rdata_i  (sram_rdata_i),
    .sram_addr_o   (sram_addr_o),
    .sram_we_o     (sram_we_o),
    .sram_re_o     (sram_re_o),
    .sram_wdata_o  (sram_wdata_o),
    .rdata_o       (rdata_o),
    .rdata_valid_o (rdata_valid_o)
  );
endmodule

// File: rtl/dxu_dual_dptr_chk.sv
module dxu_dual_dptr_chk
  import dxu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AUX_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cmd_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_valid_o,
  input logic [ADDR_W-1:0] dptr_o,
  input logic [AUX_W-1:0]  aux_o,
  input logic              sram_we_o,
  input logic              sram_re_o,
  input logic [DATA_W-1:0] sram_wdata_o
);
  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_we_o && sram_re_o));

  assert_undef_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i >= 4'd10 || cmd_i == 4'd0) |-> (!sram_we_o && !sram_re_o));

  assert_read_return_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_re_o |=> rdata_valid_o);

  assert_no_spurious_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_re_o |=> !rdata_valid_o);

  assert_rdata_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_valid_o |-> rdata_o == '0);

  assert_step_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_STEP && dptr_o == '1) |=> dptr_o == '0);

  assert_aux_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_AUX_UP |=> aux_o == AUX_W'($past(aux_o) + 1'b1));

  assert_fcopy_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_FCOPY |-> (sram_we_o && sram_wdata_o == acc_i));
endmodule

bind dxu_dual_dptr dxu_dual_dptr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUX_W(AUX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_i         (cmd_i),
  .acc_i         (acc_i),
  .rdata_o       (rdata_o),
  .rdata_valid_o (rdata_valid_o),
  .dptr_o        (dptr_o),
  .aux_o         (aux_o),
  .sram_we_o     (sram_we_o),
  .sram_re_o     (sram_re_o),
  .sram_wdata_o  (sram_wdata_o)
);

// File: tb/dxu_dual_dptr_bench.sv
module dxu_dual_dptr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_i = '0;
  logic [15:0] imm_i = '0;
  logic [7:0]  ri_i = '0, page_i = '0, acc_i = '0;
  logic [7:0]  rdata_o, sram_wdata_o, sram_rdata_q;
  logic        rdata_valid_o, sram_we_o, sram_re_o;
  logic [15:0] dptr_o, sram_addr_o;
  logic [7:0]  aux_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  sram [int];
  logic [7:0]  shadow [int];
  logic [15:0] dp [2];
  logic [7:0]  aux;
  logic [7:0]  exp_q [$];

  always #5 clk = ~clk;

  dxu_dual_dptr u_dxu_dual_dptr (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd_i), .imm_i(imm_i), .ri_i(ri_i),
    .page_i(page_i), .acc_i(acc_i), .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o),
    .dptr_o(dptr_o), .aux_o(aux_o), .sram_addr_o(sram_addr_o), .sram_we_o(sram_we_o),
    .sram_re_o(sram_re_o), .sram_wdata_o(sram_wdata_o), .sram_rdata_i(sram_rdata_q)
  );

  // synchronous SRAM model
  always @(posedge clk) begin
    if (sram_re_o) sram_rdata_q <= sram.exists(int'(sram_addr_o)) ? sram[int'(sram_addr_o)] : 8'h00;
    if (sram_we_o) sram[int'(sram_addr_o)] = sram_wdata_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  // monitor: pops expected read data (R5, R7, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdata_valid_o) begin
        if (exp_q.size() == 0) chk("R5 unexpected valid", 32'(rdata_o), 32'hFFFF_FFFF);
        else chk("R5/R7 read data", 32'(rdata_o), 32'(exp_q.pop_front()));
      end else if (rdata_o !== 8'h00) begin
        chk("R10 rdata idle zero", 32'(rdata_o), 32'h0);
      end
    end
  end

  task automatic do_cmd(input logic [3:0] c, input logic [15:0] imm,
                        input logic [7:0] pg, input logic [7:0] ri, input logic [7:0] acc);
    logic        e_we, e_re, s;
    logic [15:0] e_addr;
    @(negedge clk);
    s = aux[0];
    chk("R2 active pointer", 32'(dptr_o), 32'(dp[s]));
    chk("R3 aux register", 32'(aux_o), 32'(aux));
    cmd_i = c; imm_i = imm; page_i = pg; ri_i = ri; acc_i = acc;
    #1;
    e_we = (c == 4'd4) || (c == 4'd6) || (c == 4'd7);
    e_re = (c == 4'd3) || (c == 4'd5);
    e_addr = (c == 4'd5 || c == 4'd6) ? {pg, ri} : (c == 4'd7) ? dp[1] : dp[s];
    chk("R6/R9 write strobe", 32'(sram_we_o), 32'(e_we));
    chk("R5/R9 read strobe", 32'(sram_re_o), 32'(e_re));
    if (e_we || e_re) chk("R5/R6/R7/R8 address", 32'(sram_addr_o), 32'(e_addr));
    if (e_we) chk("R6/R8 write data", 32'(sram_wdata_o), 32'(acc));
    @(posedge clk);
    if (e_re) exp_q.push_back(mem_rd(e_addr));
    if (e_we) shadow[int'(e_addr)] = acc;
    case (c)
      4'd1: dp[s] = imm;
      4'd2: dp[s] = dp[s] + 16'd1;
      4'd7: dp[1] = dp[1] + 16'd1;
      4'd8: aux = aux + 8'd1;
      4'd9: aux = aux - 8'd1;
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_cmd(4'd0, 16'h0, 8'h0, 8'h0, 8'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dp[0] = '0; dp[1] = '0; aux = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pointer", 32'(dptr_o), 32'h0);
    chk("R1 reset aux", 32'(aux_o), 32'h0);
    chk("R1 reset valid", 32'(rdata_valid_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 idle write strobe", 32'(sram_we_o), 32'h0);
    chk("R1 idle read strobe", 32'(sram_re_o), 32'h0);
    idle(1);

    // R2 R6 R5: pointer 0 load, write, read
    do_cmd(4'd1, 16'h1234, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd4, 16'h0, 8'h0, 8'h0, 8'hA1);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);
    idle(1);

    // R3: switch to pointer 1, load, switch back
    do_cmd(4'd8, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd1, 16'h2000, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd9, 16'h0, 8'h0, 8'h0, 8'h0);

    // R8: fast copy with select 0 uses pointer 1
    do_cmd(4'd7, 16'h0, 8'h0, 8'h0, 8'h5A);
    do_cmd(4'd7, 16'h0, 8'h0, 8'h0, 8'h5B);
    do_cmd(4'd7, 16'h0, 8'h0, 8'h0, 8'h5C);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0); // pointer 0 still 0x1234

    // R8 with select 1; back-to-back reads R5
    do_cmd(4'd8, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd7, 16'h0, 8'h0, 8'h0, 8'h66);
    do_cmd(4'd1, 16'h2001, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd2, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd2, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);

    // R7: paged index accesses overlap pointer data
    do_cmd(4'd6, 16'h0, 8'h12, 8'h34, 8'h77);
    do_cmd(4'd9, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd5, 16'h0, 8'h20, 8'h00, 8'h0);
    do_cmd(4'd5, 16'h0, 8'h20, 8'h03, 8'h0);

    // R4: wrap of the active pointer
    do_cmd(4'd1, 16'hFFFF, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd2, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);

    // R8: fast copy wrap of pointer 1 (select 0 active)
    do_cmd(4'd8, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd1, 16'hFFFF, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd9, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd7, 16'h0, 8'h0, 8'h0, 8'hC3);
    do_cmd(4'd7, 16'h0, 8'h0, 8'h0, 8'hC4);
    do_cmd(4'd8, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd9, 16'h0, 8'h0, 8'h0, 8'h0);

    // R9: undefined codes do nothing
    for (int c = 10; c < 16; c++) do_cmd(4'(c), 16'hBEEF, 8'h55, 8'hAA, 8'hEE);

    // R3: down from zero wraps to 0xFF and selects pointer 1
    do_cmd(4'd9, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd3, 16'h0, 8'h0, 8'h0, 8'h0);
    do_cmd(4'd8, 16'h0, 8'h0, 8'h0, 8'h0);
    idle(3);

    chk("R5 all reads returned", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule